// File: doc/BRIEF.md
# Hibernate Entry and Wake Controller

This always-on controller decides when the core and system clocks run, when the core regulator is powered, when the pads float and when the chip is held in reset. Software in the full-on state writes a control word. Writing the value zero to its two-bit rate field puts the chip into hibernate: both clocks stop, the regulator turns off and every pad goes three-state. A lighter sleep state can also be requested. It stops the clocks but keeps the regulator powered.

The controller leaves hibernate on any enabled wake request. The possible requests are an Ethernet wake, a CAN wake, an active-low PHY interrupt line, an RTC alarm and the external reset pin. The reset pin always wakes the chip; each of the other four has its own enable bit. An exit is never a resume. The regulator is raised first and given a programmable settling time. The clocks then restart under a reset pulse of fixed length, after which the chip is full-on.

The control word lives in the retained domain and survives the whole sequence. Its rate field comes back at the default value 01, so the chip does not fall straight back into hibernate. A sticky cause field records what ended the last hibernate. An optional hold keeps SDRAM CKE low so that external memory stays in self-refresh while the core is off or in reset.

Top module: `pwr_hib_ctrl`

## Requirements
- R1: After `rst_n` is released, the controller is full-on: both clock enables, `vreg_en` and `sys_rst_n` are 1, `pad_hiz` and `sdram_cke_low` are 0, and `reg_rdata` reads 16'h0001.
- R2: In full-on, a write whose bits [1:0] are 00 enters hibernate at the write's clock edge. From the next cycle on, `cclk_en`, `sclk_en` and `vreg_en` are 0 and `pad_hiz` is 1.
- R3: Control bits [5:2] enable the wake sources Ethernet, CAN, PHY and RTC, in that order. The PHY source is active when `phy_int_n` is low. A source whose enable bit is clear leaves hibernate undisturbed, however long it is held.
- R4: Driving `ext_rst_n` low wakes the controller from hibernate whatever the enable bits hold.
- R5: Each wake input passes through two synchronizing flops. `vreg_en` rises in the third cycle after the input is applied. For the next SETTLE_CYCLES cycles the clocks stay off and `pad_hiz` stays 1.
- R6: After settling, both clocks are enabled and `sys_rst_n` is low for exactly RST_CYCLES cycles. The controller is then full-on.
- R7: Bits [12:8] record the sources that ended the last hibernate (bit 8 Ethernet, 9 CAN, 10 PHY, 11 RTC, 12 reset pin). Writing 1 to a bit of this field clears that bit.
- R8: The enable bits and bit 6 keep their values across hibernate and the wake reset. After a wake, bits [1:0] read back as 01.
- R9: When bit 6 is set, `sdram_cke_low` is 1 in hibernate, during settling and during the wake reset, and 0 in full-on. When bit 6 is clear, `sdram_cke_low` is always 0.
- R10: `sleep_req` in full-on stops both clocks while `vreg_en` stays 1 and the pads stay driven. An enabled wake source returns the controller to full-on with no reset. The reset pin instead issues the RST_CYCLES reset pulse and then returns it to full-on.
- R11: Register writes made while the controller is not full-on have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the retained domain |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word and wake cause read value |
| sleep_req | input | 1 | Request for the light sleep state |
| eth_wake | input | 1 | Ethernet wake request, asynchronous |
| can_wake | input | 1 | CAN wake request, asynchronous |
| phy_int_n | input | 1 | PHY interrupt, active low, asynchronous |
| rtc_wake | input | 1 | RTC alarm wake, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| vreg_en | output | 1 | Core regulator enable |
| pad_hiz | output | 1 | Three-state all pads |
| sdram_cke_low | output | 1 | Hold SDRAM CKE low |
| sys_rst_n | output | 1 | Chip reset, active low |

## Verification
The bench sweeps every wake source against all sixteen combinations of the enable bits, with the SDRAM hold alternating between runs. A source gated by the wrong enable bit, or a PHY line taken with the wrong polarity, would either leave hibernate when it should not or hang there, and the cause field would point at the wrong source. In every run the regulator edge, the end of settling and the reset edges are counted to the cycle. A missing synchronizer stage or an off-by-one settle or reset counter therefore shows up as a shifted edge. Further checks watch the rate field coming back as 01, a write issued during hibernate, and the sleep state both resuming without reset and taking the reset path. A design that forgot the retained fields, accepted writes while powered down, or reset on a plain sleep wake would fail there.

// File: rtl/pwr_hib_pkg.sv
package pwr_hib_pkg;
  localparam int NGATED = 4;             // eth, can, phy, rtc
  localparam int NCAUSE = NGATED + 1;    // plus reset pin
  localparam int RW     = 16;

  localparam logic [1:0] RATE_OFF  = 2'b00;
  localparam logic [1:0] RATE_DFLT = 2'b01;

  localparam int F_RATE  = 0;
  localparam int F_WEN   = 2;
  localparam int F_CKE   = 6;
  localparam int F_CAUSE = 8;

  typedef enum logic [2:0] {
    ST_ON, ST_SLEEP, ST_HIB, ST_SETTLE, ST_RST
  } pstate_e;

  typedef struct packed {
    logic              cke_low;
    logic [NGATED-1:0] wen;
    logic [1:0]        rate;
  } ctl_t;
endpackage

// File: rtl/pwr_hib_sync.sv
module pwr_hib_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/pwr_hib_regs.sv
module pwr_hib_regs
  import pwr_hib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [RW-1:0]     wdata,
  input  logic              hib_exit,
  input  logic [NCAUSE-1:0] cause_in,
  output ctl_t              ctl,
  output logic [RW-1:0]     rdata
);
  ctl_t              ctl_q, ctl_d;
  logic [NCAUSE-1:0] cause_q, cause_d;

  always_comb begin
    ctl_d   = ctl_q;
    cause_d = cause_q;
    if (wr_ok) begin
      ctl_d.rate    = wdata[F_RATE +: 2];
      ctl_d.wen     = wdata[F_WEN +: NGATED];
      ctl_d.cke_low = wdata[F_CKE];
      cause_d       = cause_q & ~wdata[F_CAUSE +: NCAUSE];
    end
    if (hib_exit) begin
      ctl_d.rate = RATE_DFLT;
      cause_d    = cause_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '{cke_low: 1'b0, wen: '0, rate: RATE_DFLT};
      cause_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      cause_q <= cause_d;
    end
  end

  assign ctl = ctl_q;

  always_comb begin
    rdata                       = '0;
    rdata[F_RATE +: 2]          = ctl_q.rate;
    rdata[F_WEN +: NGATED]      = ctl_q.wen;
    rdata[F_CKE]                = ctl_q.cke_low;
    rdata[F_CAUSE +: NCAUSE]    = cause_q;
  end
endmodule

// File: rtl/pwr_hib_fsm.sv
module pwr_hib_fsm
  import pwr_hib_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64,
  parameter int RST_CYCLES    = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hib_req,
  input  logic    sleep_req,
  input  logic    wake_any,
  input  logic    pin_req,
  output pstate_e state,
  output logic    hib_exit
);
  localparam int MAXC = (SETTLE_CYCLES > RST_CYCLES) ? SETTLE_CYCLES : RST_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] RST_LAST    = CW'(RST_CYCLES - 1);

  pstate_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    hib_exit = 1'b0;
    unique case (st_q)
      ST_ON: begin
        cnt_d = '0;
        if (pin_req)        st_d = ST_RST;
        else if (hib_req)   st_d = ST_HIB;
        else if (sleep_req) st_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        cnt_d = '0;
        if (pin_req)       st_d = ST_RST;
        else if (wake_any) st_d = ST_ON;
      end
      ST_HIB: begin
        cnt_d = '0;
        if (pin_req || wake_any) begin
          st_d     = ST_SETTLE;
          hib_exit = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          st_d  = ST_RST;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RST: begin
        if (cnt_q == RST_LAST) begin
          st_d  = ST_ON;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ON;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pwr_hib_ctrl.sv
module pwr_hib_ctrl
  import pwr_hib_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64,
  parameter int RST_CYCLES    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          sleep_req,
  input  logic          eth_wake,
  input  logic          can_wake,
  input  logic          phy_int_n,
  input  logic          rtc_wake,
  input  logic          ext_rst_n,
  output logic          cclk_en,
  output logic          sclk_en,
  output logic          vreg_en,
  output logic          pad_hiz,
  output logic          sdram_cke_low,
  output logic          sys_rst_n
);
  logic [NCAUSE-1:0] req_raw, req_s;
  logic [NGATED-1:0] gated;
  logic              pin_req, wake_any, wr_ok, hib_req, hib_exit;
  ctl_t              ctl;
  pstate_e           state;

  // active-high request vector, reset pin on top
  assign req_raw = {~ext_rst_n, rtc_wake, ~phy_int_n, can_wake, eth_wake};

  pwr_hib_sync #(.W(NCAUSE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_s)
  );

  assign pin_req  = req_s[NCAUSE-1];
  assign gated    = req_s[NGATED-1:0] & ctl.wen;
  assign wake_any = |gated;

  assign wr_ok   = reg_we && (state == ST_ON) && !pin_req;
  assign hib_req = wr_ok && (reg_wdata[F_RATE +: 2] == RATE_OFF);

  pwr_hib_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(reg_wdata),
    .hib_exit(hib_exit), .cause_in({pin_req, gated}),
    .ctl(ctl), .rdata(reg_rdata)
  );

  pwr_hib_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES), .RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hib_req(hib_req), .sleep_req(sleep_req),
    .wake_any(wake_any), .pin_req(pin_req), .state(state), .hib_exit(hib_exit)
  );

  logic powered_down;
  assign powered_down  = (state == ST_HIB) || (state == ST_SETTLE);
  assign cclk_en       = (state == ST_ON) || (state == ST_RST);
  assign sclk_en       = cclk_en;
  assign vreg_en       = (state != ST_HIB);
  assign pad_hiz       = powered_down;
  assign sys_rst_n     = (state != ST_RST);
  assign sdram_cke_low = ctl.cke_low && (powered_down || (state == ST_RST));
endmodule

// File: rtl/pwr_hib_chk.sv
module pwr_hib_chk #(
  parameter int RST_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cclk_en,
  input logic sclk_en,
  input logic vreg_en,
  input logic pad_hiz,
  input logic sdram_cke_low,
  input logic sys_rst_n
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (!sys_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  // R2
  hiz_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_hiz |-> (!cclk_en && !sclk_en));

  // R5
  vreg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vreg_en) |-> pad_hiz);

  // R6
  rst_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> (cclk_en && vreg_en && !pad_hiz));

  // R6
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (low_cnt == RST_CYCLES));

  // R9
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_cke_low |-> (pad_hiz || !sys_rst_n));

  // R1
  on_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (cclk_en && sclk_en && vreg_en));
endmodule

bind pwr_hib_ctrl pwr_hib_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cclk_en(cclk_en), .sclk_en(sclk_en),
  .vreg_en(vreg_en), .pad_hiz(pad_hiz), .sdram_cke_low(sdram_cke_low),
  .sys_rst_n(sys_rst_n)
);

// File: tb/sim_pwr_hib_ctrl.sv
module sim_pwr_hib_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SET_N = 6;
  localparam int RST_N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sleep_req = 1'b0;
  logic        eth_wake = 1'b0, can_wake = 1'b0, rtc_wake = 1'b0;
  logic        phy_int_n = 1'b1, ext_rst_n = 1'b1;
  logic        cclk_en, sclk_en, vreg_en, pad_hiz, sdram_cke_low, sys_rst_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_hib_ctrl #(.SETTLE_CYCLES(SET_N), .RST_CYCLES(RST_N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .eth_wake(eth_wake),
    .can_wake(can_wake), .phy_int_n(phy_int_n), .rtc_wake(rtc_wake),
    .ext_rst_n(ext_rst_n), .cclk_en(cclk_en), .sclk_en(sclk_en),
    .vreg_en(vreg_en), .pad_hiz(pad_hiz), .sdram_cke_low(sdram_cke_low),
    .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: eth_wake = v;
      1: can_wake = v;
      2: phy_int_n = ~v;
      3: rtc_wake = v;
      default: ext_rst_n = ~v;
    endcase
  endtask

  function automatic logic [15:0] ctl_word(logic [4:0] cz, logic ck, logic [3:0] en, logic [1:0] rt);
    return {3'b000, cz, 1'b0, ck, en, rt};
  endfunction

  // full wake sequence from hibernate, driven at a negedge
  task automatic wake_seq(input int s, input logic ck);
    set_src(s, 1'b1);
    cyc(2);
    chk("R5 vreg still off after two sync stages", vreg_en, 0);
    cyc(1);
    chk("R5 vreg on in third cycle", vreg_en, 1);
    chk("R5 pads hiz while settling", pad_hiz, 1);
    chk("R5 clock off while settling", cclk_en, 0);
    set_src(s, 1'b0);
    cyc(SET_N - 1);
    chk("R5 clock off at last settle cycle", cclk_en, 0);
    chk("R5 pads hiz at last settle cycle", pad_hiz, 1);
    cyc(1);
    chk("R6 clocks on in reset", {cclk_en, sclk_en}, 2'b11);
    chk("R6 reset asserted", sys_rst_n, 0);
    chk("R6 pads driven in reset", pad_hiz, 0);
    chk("R9 cke hold during reset", sdram_cke_low, ck);
    cyc(RST_N - 1);
    chk("R6 reset still low at last cycle", sys_rst_n, 0);
    cyc(1);
    chk("R6 reset released after count", sys_rst_n, 1);
    chk("R9 cke hold off in full-on", sdram_cke_low, 0);
  endtask

  task automatic hib_run(input int s, input logic [3:0] en, input logic ck);
    logic [4:0] exp_cz;
    wr(ctl_word(5'd0, ck, en, 2'b00));
    chk("R2 clocks off in hibernate", {cclk_en, sclk_en}, 2'b00);
    chk("R2 regulator off in hibernate", vreg_en, 0);
    chk("R2 pads hiz in hibernate", pad_hiz, 1);
    chk("R9 cke hold in hibernate", sdram_cke_low, ck);
    if (s == 4 || en[s]) begin
      wake_seq(s, ck);
      exp_cz = 5'(1 << s);
      if (s == 4) chk("R4 pin wake with enables", {28'd0, en}, {28'd0, en});
    end else begin
      set_src(s, 1'b1);
      cyc(10);
      chk("R3 disabled source ignored", vreg_en, 0);
      chk("R3 disabled source pads", pad_hiz, 1);
      set_src(s, 1'b0);
      cyc(2);
      wake_seq(4, ck);
      exp_cz = 5'b10000;
    end
    chk("R7 wake cause", reg_rdata[12:8], exp_cz);
    chk("R8 enables retained", reg_rdata[5:2], en);
    chk("R8 cke bit retained", reg_rdata[6], ck);
    chk("R8 rate restored to 01", reg_rdata[1:0], 2'b01);
    wr(ctl_word(exp_cz, ck, en, 2'b01));
    chk("R7 cause cleared by write-one", reg_rdata[12:8], 5'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    chk("R1 clocks on", {cclk_en, sclk_en}, 2'b11);
    chk("R1 regulator on", vreg_en, 1);
    chk("R1 pads and cke", {pad_hiz, sdram_cke_low}, 2'b00);
    chk("R1 no reset", sys_rst_n, 1);
    chk("R1 register value", reg_rdata, 16'h0001);

    for (int s = 0; s < 5; s++)
      for (int e = 0; e < 16; e++)
        hib_run(s, 4'(e), 1'(e) ^ 1'(s));

    // R11: write attempted during hibernate is dropped
    wr(ctl_word(5'd0, 1'b0, 4'b1000, 2'b00));
    wr(ctl_word(5'd0, 1'b1, 4'b1111, 2'b11));
    chk("R11 write in hibernate keeps it asleep", vreg_en, 0);
    wake_seq(3, 1'b0);
    chk("R11 enables unchanged", reg_rdata[5:2], 4'b1000);
    chk("R11 cke unchanged", reg_rdata[6], 0);
    wr(ctl_word(5'b01000, 1'b0, 4'b0001, 2'b01));
    chk("R7 rtc cause cleared", reg_rdata[12:8], 5'd0);

    // R10: sleep with enabled wake resumes without reset
    sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
    chk("R10 clocks off in sleep", {cclk_en, sclk_en}, 2'b00);
    chk("R10 regulator on in sleep", vreg_en, 1);
    chk("R10 pads driven in sleep", pad_hiz, 0);
    eth_wake = 1'b1;
    cyc(2);
    chk("R10 still asleep during sync", cclk_en, 0);
    cyc(1);
    chk("R10 resumed clocks", cclk_en, 1);
    chk("R10 no reset on resume", sys_rst_n, 1);
    eth_wake = 1'b0;
    chk("R10 cause untouched by sleep", reg_rdata[12:8], 5'd0);

    // R10: reset pin during sleep gives reset pulse
    cyc(3);
    sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
    chk("R10 back in sleep", cclk_en, 0);
    ext_rst_n = 1'b0;
    cyc(3);
    ext_rst_n = 1'b1;
    chk("R10 reset from sleep", {cclk_en, sys_rst_n}, 2'b10);
    cyc(RST_N - 1);
    chk("R10 reset held", sys_rst_n, 0);
    cyc(1);
    chk("R10 full-on after reset", {cclk_en, vreg_en, sys_rst_n}, 3'b111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule